// File: doc/BRIEF.md
# Write-Status Byte Generator

This block supplies the byte returned on a read while the device is busy with an internal program or erase. A start pulse, issued once the final strobe of a command sequence has been accepted, launches an internal operation of a chosen kind. A counter then holds the block busy for a parameterised number of clock cycles for that kind. Durations are kept short so that simulation stays fast.

While the block is busy, every read returns a status byte. The top bit is a polling flag. A program drives it with the complement of the top bit of the byte being written. An erase forces it to 0. The next bit down is a toggle flag that changes on each new read access. The remaining low bits carry the array input unchanged; their value has no meaning while the operation runs. Once busy drops, the array input passes through untouched, so polling software sees the true value and a toggle bit that has stopped changing.

Top module: `wsg_status_gen`

## Requirements
- R1: A start_i pulse while idle, with op_i equal to 0 (program), 1 (sector/block erase) or 2 (chip erase), sets busy_o from the next cycle. busy_o then stays high for exactly PROG_CYC, SECT_CYC or CHIP_CYC cycles respectively.
- R2: While a program runs, rd_data_o[DW-1] is the inverse of the prog_msb_i value captured with the start pulse. Later changes of prog_msb_i have no effect.
- R3: While either erase kind runs, rd_data_o[DW-1] is 0.
- R4: While busy, rd_data_o[DW-2] takes opposite values in two consecutive read accesses. An access begins when rd_en_i (active high, the combined chip/output enable) rises. Read data is valid from the second cycle of the access.
- R5: While busy, rd_data_o[DW-2] holds its value when no access begins, including during a long access with rd_en_i held high.
- R6: While busy, rd_data_o[DW-3:0] equals arr_data_i[DW-3:0].
- R7: While idle, rd_data_o equals arr_data_i on all bits. This includes the cycles after an operation completes, so an erased location reads all ones.
- R8: A start_i pulse while busy is ignored and does not change the running duration. A start_i pulse with op_i equal to 3 is ignored and leaves busy_o low.
- R9: While rst_ni is low, busy_o is 0 and rd_data_o equals arr_data_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch pulse for an internal operation |
| op_i | input | 2 | Operation kind: 0 program, 1 sector/block erase, 2 chip erase, 3 none |
| prog_msb_i | input | 1 | Top bit of the byte being programmed |
| rd_en_i | input | 1 | Read access active (combined chip and output enable, active high) |
| arr_data_i | input | DW | Data from the array location being read |
| busy_o | output | 1 | Internal operation in progress |
| rd_data_o | output | DW | Read data: status byte while busy, array data otherwise |

## Verification
A vector table runs program, sector erase and chip erase operations with written bytes whose top bit is both set and clear. Each pattern is paired with array data chosen so that the inverted bit, the forced zero and the passed-through bits can each be told apart. Each operation is read twice during busy to show the toggle alternating. Afterwards the operation is read once idle, which separates status output from true data, and the busy length is measured to tell the three durations apart. Directed cases hold a read open to show the toggle staying put, restart during busy and with the reserved code, and change the program bit mid-operation.

// File: rtl/wsg_pkg.sv
package wsg_pkg;
  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_SECT = 2'd1,
    OP_CHIP = 2'd2,
    OP_NONE = 2'd3
  } op_e;
endpackage

// File: rtl/wsg_busy_timer.sv
module wsg_busy_timer #(
  parameter int PROG_CYC = 20,
  parameter int SECT_CYC = 40,
  parameter int CHIP_CYC = 70
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  wsg_pkg::op_e  op_i,
  output logic          accept_o,
  output logic          busy_o
);
  import wsg_pkg::*;

  localparam int MAX_A = (PROG_CYC > SECT_CYC) ? PROG_CYC : SECT_CYC;
  localparam int MAX_C = (MAX_A > CHIP_CYC) ? MAX_A : CHIP_CYC;
  localparam int CW    = $clog2(MAX_C + 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;
  logic [CW-1:0] load_val;

  always_comb begin
    case (op_i)
      OP_SECT: load_val = CW'(SECT_CYC - 1);
      OP_CHIP: load_val = CW'(CHIP_CYC - 1);
      default: load_val = CW'(PROG_CYC - 1);
    endcase
  end

  assign accept_o = start_i && !busy_q && (op_i != OP_NONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (accept_o) begin
      busy_q <= 1'b1;
      cnt_q  <= load_val;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy_o = busy_q;
endmodule

// File: rtl/wsg_toggle.sv
module wsg_toggle (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_en_i,
  input  logic busy_i,
  output logic tog_o
);
  logic rd_q;
  logic tog_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= 1'b0;
      tog_q <= 1'b0;
    end else begin
      rd_q <= rd_en_i;
      // one flip per access start, only during an operation
      if (busy_i && rd_en_i && !rd_q) tog_q <= ~tog_q;
    end
  end

  assign tog_o = tog_q;
endmodule

// File: rtl/wsg_status_mux.sv
module wsg_status_mux #(
  parameter int DW = 8
) (
  input  logic          busy_i,
  input  logic          erase_i,
  input  logic          prog_msb_i,
  input  logic          tog_i,
  input  logic [DW-1:0] arr_data_i,
  output logic [DW-1:0] rd_data_o
);
  logic poll_bit;

  assign poll_bit = erase_i ? 1'b0 : ~prog_msb_i;

  always_comb begin
    rd_data_o = arr_data_i;
    if (busy_i) begin
      rd_data_o[DW-1] = poll_bit;
      rd_data_o[DW-2] = tog_i;
    end
  end
endmodule

// File: rtl/wsg_status_gen.sv
module wsg_status_gen #(
  parameter int DW       = 8,
  parameter int PROG_CYC = 20,
  parameter int SECT_CYC = 40,
  parameter int CHIP_CYC = 70
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [1:0]    op_i,
  input  logic          prog_msb_i,
  input  logic          rd_en_i,
  input  logic [DW-1:0] arr_data_i,
  output logic          busy_o,
  output logic [DW-1:0] rd_data_o
);
  import wsg_pkg::*;

  op_e  op;
  logic accept;
  logic busy;
  logic tog;
  logic erase_q;
  logic msb_q;

  assign op = op_e'(op_i);

  wsg_busy_timer #(
    .PROG_CYC(PROG_CYC),
    .SECT_CYC(SECT_CYC),
    .CHIP_CYC(CHIP_CYC)
  ) i_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .op_i    (op),
    .accept_o(accept),
    .busy_o  (busy)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      erase_q <= 1'b0;
      msb_q   <= 1'b0;
    end else if (accept) begin
      erase_q <= (op != OP_PROG);
      msb_q   <= prog_msb_i;
    end
  end

  wsg_toggle i_toggle (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rd_en_i(rd_en_i),
    .busy_i (busy),
    .tog_o  (tog)
  );

  wsg_status_mux #(.DW(DW)) i_mux (
    .busy_i    (busy),
    .erase_i   (erase_q),
    .prog_msb_i(msb_q),
    .tog_i     (tog),
    .arr_data_i(arr_data_i),
    .rd_data_o (rd_data_o)
  );

  assign busy_o = busy;
endmodule

// File: rtl/wsg_status_chk.sv
module wsg_status_chk #(
  parameter int DW       = 8,
  parameter int PROG_CYC = 20,
  parameter int SECT_CYC = 40,
  parameter int CHIP_CYC = 70
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic [1:0]    op_i,
  input logic          prog_msb_i,
  input logic          rd_en_i,
  input logic [DW-1:0] arr_data_i,
  input logic          busy_o,
  input logic [DW-1:0] rd_data_o
);
  logic        rd_prev;
  logic        kind_erase;
  logic        kind_msb;
  int unsigned len;
  int unsigned exp_len;
  logic        acc;
  logic        rd_rise;

  assign acc     = start_i && !busy_o && (op_i != 2'd3);
  assign rd_rise = rd_en_i && !rd_prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_prev    <= 1'b0;
      kind_erase <= 1'b0;
      kind_msb   <= 1'b0;
      len        <= 0;
      exp_len    <= 0;
    end else begin
      rd_prev <= rd_en_i;
      len     <= busy_o ? len + 1 : 0;
      if (acc) begin
        kind_erase <= (op_i != 2'd0);
        kind_msb   <= prog_msb_i;
        exp_len    <= (op_i == 2'd0) ? PROG_CYC : (op_i == 2'd1) ? SECT_CYC : CHIP_CYC;
      end
    end
  end

  a_r1_busy_rises: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> busy_o);
  a_r1_duration: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (len == exp_len));
  a_r2_prog_poll: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !kind_erase) |-> (rd_data_o[DW-1] == ~kind_msb));
  a_r3_erase_poll: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && kind_erase) |-> (rd_data_o[DW-1] == 1'b0));
  a_r4_toggle_flips: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && rd_rise) |=> (!busy_o || (rd_data_o[DW-2] != $past(rd_data_o[DW-2]))));
  a_r5_toggle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !rd_rise) |=> (!busy_o || $stable(rd_data_o[DW-2])));
  a_r6_low_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (rd_data_o[DW-3:0] == arr_data_i[DW-3:0]));
  a_r7_idle_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (rd_data_o == arr_data_i));
  a_r8_none_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && op_i == 2'd3) |=> !busy_o);
endmodule

bind wsg_status_gen wsg_status_chk #(
  .DW(DW), .PROG_CYC(PROG_CYC), .SECT_CYC(SECT_CYC), .CHIP_CYC(CHIP_CYC)
) i_wsg_status_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .op_i(op_i),
  .prog_msb_i(prog_msb_i), .rd_en_i(rd_en_i), .arr_data_i(arr_data_i),
  .busy_o(busy_o), .rd_data_o(rd_data_o)
);

// File: tb/test_wsg_status_gen.sv
module test_wsg_status_gen;
  localparam int DW = 8;
  localparam int PC = 20;
  localparam int SC = 40;
  localparam int CC = 70;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [1:0]    op = 2'd0;
  logic          prog_msb = 1'b0;
  logic          rd = 1'b0;
  logic [DW-1:0] arr = '0;
  logic          busy;
  logic [DW-1:0] rd_data;

  int cyc = 0;
  int errors = 0;
  int checks = 0;

  // {op, written byte, array byte}
  localparam logic [17:0] VECS [6] = '{
    {2'd0, 8'h80, 8'h3C},
    {2'd0, 8'h7F, 8'hC3},
    {2'd1, 8'h00, 8'hFF},
    {2'd2, 8'hFF, 8'hFF},
    {2'd0, 8'h00, 8'hA5},
    {2'd1, 8'h55, 8'h0F}
  };

  wsg_status_gen #(.DW(DW), .PROG_CYC(PC), .SECT_CYC(SC), .CHIP_CYC(CC)) i_wsg_status_gen (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .prog_msb_i(prog_msb),
    .rd_en_i(rd), .arr_data_i(arr), .busy_o(busy), .rd_data_o(rd_data)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc++;

  always @(posedge clk) begin
    if (cyc > 100000) begin
      errors++;
      $display("FAIL R1..: watchdog actual=%0d expected<=100000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int dur_of(input logic [1:0] o);
    return (o == 2'd0) ? PC : (o == 2'd1) ? SC : CC;
  endfunction

  task automatic pulse_start(input logic [1:0] o, input logic msb);
    @(negedge clk);
    start = 1'b1; op = o; prog_msb = msb;
    @(negedge clk);
    start = 1'b0; prog_msb = ~msb;
  endtask

  task automatic do_read(output logic [DW-1:0] v);
    rd = 1'b1;
    @(negedge clk);
    @(negedge clk);
    v = rd_data;
    rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic wait_idle(input int t0, output int n);
    while (busy) @(negedge clk);
    n = cyc - t0;
  endtask

  initial begin
    logic [DW-1:0] r1, r2, r3;
    int t0, n;

    arr = 8'h5A;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R9 busy in reset", busy, 0);
    chk(rd_data == 8'h5A, "R9 data in reset", rd_data, 8'h5A);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 6; i++) begin
      logic [1:0]    vo;
      logic [DW-1:0] vw, va, e7;
      {vo, vw, va} = VECS[i];
      arr = va;
      pulse_start(vo, vw[7]);
      t0 = cyc;
      chk(busy == 1'b1, "R1 busy after start", busy, 1);
      do_read(r1);
      do_read(r2);
      e7 = (vo == 2'd0) ? {7'd0, ~vw[7]} : 8'd0;
      chk(r1[7] == e7[0], (vo == 2'd0) ? "R2 poll read1" : "R3 poll read1", r1[7], e7[0]);
      chk(r2[7] == e7[0], (vo == 2'd0) ? "R2 poll read2" : "R3 poll read2", r2[7], e7[0]);
      chk(r1[6] != r2[6], "R4 toggle alternates", r2[6], ~r1[6]);
      chk(r2[5:0] == va[5:0], "R6 low bits", r2[5:0], va[5:0]);
      wait_idle(t0, n);
      chk(n == dur_of(vo), "R1 busy length", n, dur_of(vo));
      do_read(r3);
      chk(r3 == va, "R7 true data after done", r3, va);
    end

    // R5: long access held open, then idle stretch with no access
    arr = 8'h12;
    pulse_start(2'd1, 1'b0);
    rd = 1'b1;
    @(negedge clk); @(negedge clk);
    r1 = rd_data;
    repeat (4) @(negedge clk);
    r2 = rd_data;
    rd = 1'b0;
    chk(r2[6] == r1[6], "R5 held access no flip", r2[6], r1[6]);
    repeat (5) @(negedge clk);
    chk(rd_data[6] == r1[6], "R5 no access no flip", rd_data[6], r1[6]);
    do_read(r3);
    chk(r3[6] != r1[6], "R4 next access flips", r3[6], ~r1[6]);
    while (busy) @(negedge clk);

    // R8: reserved kind ignored
    pulse_start(2'd3, 1'b0);
    chk(busy == 1'b0, "R8 reserved kind", busy, 0);
    @(negedge clk);
    chk(busy == 1'b0, "R8 reserved kind later", busy, 0);

    // R8: restart while busy ignored; R2 mid-op msb change ignored
    arr = 8'h00;
    pulse_start(2'd0, 1'b1);
    t0 = cyc;
    repeat (3) @(negedge clk);
    start = 1'b1; op = 2'd2;
    @(negedge clk);
    start = 1'b0;
    chk(rd_data[7] == 1'b0, "R2 captured msb kept", rd_data[7], 0);
    wait_idle(t0, n);
    chk(n == PC, "R8 restart ignored", n, PC);
    chk(rd_data == 8'h00, "R7 idle pass", rd_data, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule